// File: doc/BRIEF.md
# Secure Transaction Filter with Fault Capture

The filter sits on the path from an upstream bus to a downstream memory and decides, for each request, whether its security attribute may reach the addressed region. The region is split into equal blocks. One configuration bit per block, held in an external table of 32-bit words, states whether the block belongs to the secure or the non-secure world. The filter computes which table word to fetch, picks the block's bit, and compares it with the request's effective security. The decision is made in the same cycle as the request.

A permitted request is passed downstream in that same cycle with its fields unchanged. The downstream memory returns read data one cycle later. A denied request never reaches downstream. The filter answers it locally one cycle later with zero data and, depending on a control input, an OK or an error response. Every denial sets a sticky fault status that drives the interrupt. The first denial after the status is cleared also records the faulting address and a packed descriptor of the fault.

Top module: `secure_xact_filter`

## Requirements
- R1: The block number is the request address divided by BLK_BYTES (256), taken modulo the number of blocks in the region (256 by default, so address bits above the region wrap). `lut_idx_o` carries the block number divided by 32 in the request cycle, and the configuration bit used is bit (block number mod 32) of `lut_word_i`.
- R2: A block whose bit is 1 admits only non-secure requests. A block whose bit is 0 admits only secure requests.
- R3: A request with `up_sec_unspec_i` high is treated as secure, whatever the value of `up_sec_i`.
- R4: A permitted request raises `dn_req_o` in its own cycle, with the address, direction, write data, security and master ID copied unchanged. Its response comes one cycle later with `up_err_o` low. A read returns `dn_rdata_i`, and a write returns zero data.
- R5: A denied request never raises `dn_req_o`, so a denied write leaves the memory contents unchanged.
- R6: A denied request is answered one cycle after acceptance with zero data. `up_err_o` equals `sec_resp_i` as sampled in the request cycle.
- R7: Every denied request sets the fault status one cycle later. The status then holds until `irq_clr_i` is pulsed. If a clear and a denial arrive in the same cycle, the status stays set.
- R8: The fault record is captured only when a request is denied while the status is clear. `fault_addr_o` takes the full request address. `fault_info_o` takes the master ID in bits [15:0], the non-secure flag (the inverse of the effective security) in bit 16 and the block's configuration bit in bit 17, with all other bits zero. While the status is set, the record does not change.
- R9: `irq_o` is high exactly when the fault status is set and `irq_en_i` is high.
- R10: Each cycle with `up_req_i` high produces exactly one `up_rvalid_o` pulse in the following cycle. No response appears in any other cycle.
- R11: After reset the fault status is clear, both fault record outputs are zero and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_req_i | input | 1 | Upstream request, accepted every cycle it is high |
| up_write_i | input | 1 | 1 = write, 0 = read |
| up_addr_i | input | ADDR_W | Request byte address |
| up_wdata_i | input | DATA_W | Write data |
| up_sec_i | input | 1 | Request is secure |
| up_sec_unspec_i | input | 1 | Security attribute unspecified (treated as secure) |
| up_mid_i | input | 16 | Master ID |
| up_rvalid_o | output | 1 | Response valid, one cycle after request |
| up_err_o | output | 1 | Error response |
| up_rdata_o | output | DATA_W | Read data |
| dn_req_o | output | 1 | Downstream request |
| dn_write_o | output | 1 | Downstream direction |
| dn_addr_o | output | ADDR_W | Downstream address |
| dn_wdata_o | output | DATA_W | Downstream write data |
| dn_sec_o | output | 1 | Downstream security attribute |
| dn_mid_o | output | 16 | Downstream master ID |
| dn_rdata_i | input | DATA_W | Downstream read data, one cycle after request |
| lut_idx_o | output | WORD_W | Table word index for the current request |
| lut_word_i | input | 32 | Table word at `lut_idx_o` |
| sec_resp_i | input | 1 | Denied requests answer with error when high |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Clears the fault status |
| irq_o | output | 1 | Interrupt |
| fault_stat_o | output | 1 | Sticky fault status |
| fault_addr_o | output | ADDR_W | Captured faulting address |
| fault_info_o | output | 32 | Captured fault descriptor |

## Verification
The table index and the downstream forwarding are combinational, so the bench checks them one time step after it drives a request, in the same cycle. Responses, fault status and the fault record all change on the clock edge that accepts the request and are due in the next cycle. The driver queues every expected response at the moment it issues the request. A monitor samples one time step after each rising edge, away from the negative edge where inputs change, and pops the queue whenever `up_rvalid_o` is seen. The fault outputs are compared with a bench model once the request has been released, which is after the capturing edge.

// File: rtl/stf_pkg.sv
package stf_pkg;
  localparam int MID_W  = 16;
  localparam int WORD_BITS = 32;

  // Fault descriptor: bit positions are visible to software
  typedef struct packed {
    logic [13:0]      rsvd;
    logic             cfg_ns;
    logic             nonsec;
    logic [MID_W-1:0] mid;
  } fault_info_t;
endpackage

// File: rtl/stf_lookup.sv
module stf_lookup #(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8,
  parameter int BLK_W     = 8,
  parameter int WORD_W    = 3
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       sec_i,
  input  logic                       sec_unspec_i,
  input  logic [stf_pkg::WORD_BITS-1:0] lut_word_i,
  output logic [WORD_W-1:0]          lut_idx_o,
  output logic                       cfg_ns_o,
  output logic                       nonsec_o,
  output logic                       permit_o
);
  logic [BLK_W-1:0] blk_num;
  logic [4:0]       bit_idx;
  logic             eff_sec;

  assign blk_num = addr_i[BLK_SHIFT +: BLK_W];

  generate
    if (BLK_W > 5) begin : g_multi
      assign lut_idx_o = blk_num[BLK_W-1:5];
      assign bit_idx   = blk_num[4:0];
    end else begin : g_single
      assign lut_idx_o = '0;
      assign bit_idx   = 5'(blk_num);
    end
  endgenerate

  // unspecified attribute counts as secure
  assign eff_sec  = sec_i | sec_unspec_i;
  assign nonsec_o = ~eff_sec;
  assign cfg_ns_o = lut_word_i[bit_idx];
  assign permit_o = cfg_ns_o ^ eff_sec;
endmodule

// File: rtl/stf_fault.sv
module stf_fault #(
  parameter int ADDR_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  blk_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  stf_pkg::fault_info_t  info_i,
  input  logic                  clr_i,
  input  logic                  en_i,
  output logic                  stat_o,
  output logic                  irq_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [31:0]           info_o
);
  logic                 stat_q;
  logic [ADDR_W-1:0]    addr_q;
  stf_pkg::fault_info_t info_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      addr_q <= '0;
      info_q <= '0;
    end else begin
      if (blk_i && !stat_q) begin
        addr_q <= addr_i;
        info_q <= info_i;
      end
      // a new denial outranks a clear in the same cycle
      if (blk_i)      stat_q <= 1'b1;
      else if (clr_i) stat_q <= 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = stat_q & en_i;
  assign addr_o = addr_q;
  assign info_o = info_q;

  // R7
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_i |=> stat_o);
  // R7
  stat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o && !clr_i |=> stat_o);
  // R8
  info_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_i && !stat_o |=> (addr_o == $past(addr_i)) && (info_o == $past(info_i)));
  // R8
  info_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o |=> $stable(addr_o) && $stable(info_o));
endmodule

// File: rtl/stf_resp.sv
module stf_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              blocked_i,
  input  logic              write_i,
  input  logic              sec_resp_i,
  input  logic [DATA_W-1:0] dn_rdata_i,
  output logic              rvalid_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic vld_q, blk_q, wr_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      blk_q <= 1'b0;
      wr_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= acc_i;
      blk_q <= acc_i & blocked_i;
      wr_q  <= acc_i & write_i;
      err_q <= acc_i & blocked_i & sec_resp_i;
    end
  end

  assign rvalid_o = vld_q;
  assign err_o    = err_q;
  assign rdata_o  = (vld_q && !blk_q && !wr_q) ? dn_rdata_i : '0;

  // R10
  rsp_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> rvalid_o);
  // R10
  rsp_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> !rvalid_o);
  // R6
  blk_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && blocked_i |=> (rdata_o == '0) && (err_o == $past(sec_resp_i)));
  // R4
  ok_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !blocked_i |=> !err_o);
endmodule

// File: rtl/secure_xact_filter.sv
module secure_xact_filter #(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int BLK_BYTES    = 256,
  parameter int REGION_BYTES = 65536,
  localparam int BLK_SHIFT   = $clog2(BLK_BYTES),
  localparam int NUM_BLKS    = REGION_BYTES / BLK_BYTES,
  localparam int BLK_W       = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1,
  localparam int NUM_WORDS   = (NUM_BLKS + 31) / 32,
  localparam int WORD_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      up_req_i,
  input  logic                      up_write_i,
  input  logic [ADDR_W-1:0]         up_addr_i,
  input  logic [DATA_W-1:0]         up_wdata_i,
  input  logic                      up_sec_i,
  input  logic                      up_sec_unspec_i,
  input  logic [stf_pkg::MID_W-1:0] up_mid_i,
  output logic                      up_rvalid_o,
  output logic                      up_err_o,
  output logic [DATA_W-1:0]         up_rdata_o,
  output logic                      dn_req_o,
  output logic                      dn_write_o,
  output logic [ADDR_W-1:0]         dn_addr_o,
  output logic [DATA_W-1:0]         dn_wdata_o,
  output logic                      dn_sec_o,
  output logic [stf_pkg::MID_W-1:0] dn_mid_o,
  input  logic [DATA_W-1:0]         dn_rdata_i,
  output logic [WORD_W-1:0]         lut_idx_o,
  input  logic [31:0]               lut_word_i,
  input  logic                      sec_resp_i,
  input  logic                      irq_en_i,
  input  logic                      irq_clr_i,
  output logic                      irq_o,
  output logic                      fault_stat_o,
  output logic [ADDR_W-1:0]         fault_addr_o,
  output logic [31:0]               fault_info_o
);
  logic                 cfg_ns, nonsec, permit, blocked;
  stf_pkg::fault_info_t info_d;

  stf_lookup #(
    .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .BLK_W(BLK_W), .WORD_W(WORD_W)
  ) i_lookup (
    .addr_i      (up_addr_i),
    .sec_i       (up_sec_i),
    .sec_unspec_i(up_sec_unspec_i),
    .lut_word_i  (lut_word_i),
    .lut_idx_o   (lut_idx_o),
    .cfg_ns_o    (cfg_ns),
    .nonsec_o    (nonsec),
    .permit_o    (permit)
  );

  assign blocked    = up_req_i & ~permit;
  assign dn_req_o   = up_req_i & permit;
  assign dn_write_o = up_write_i;
  assign dn_addr_o  = up_addr_i;
  assign dn_wdata_o = up_wdata_i;
  assign dn_sec_o   = up_sec_i;
  assign dn_mid_o   = up_mid_i;

  always_comb begin
    info_d        = '0;
    info_d.mid    = up_mid_i;
    info_d.nonsec = nonsec;
    info_d.cfg_ns = cfg_ns;
  end

  stf_fault #(.ADDR_W(ADDR_W)) i_fault (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .blk_i (blocked),
    .addr_i(up_addr_i),
    .info_i(info_d),
    .clr_i (irq_clr_i),
    .en_i  (irq_en_i),
    .stat_o(fault_stat_o),
    .irq_o (irq_o),
    .addr_o(fault_addr_o),
    .info_o(fault_info_o)
  );

  stf_resp #(.DATA_W(DATA_W)) i_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (up_req_i),
    .blocked_i (~permit),
    .write_i   (up_write_i),
    .sec_resp_i(sec_resp_i),
    .dn_rdata_i(dn_rdata_i),
    .rvalid_o  (up_rvalid_o),
    .err_o     (up_err_o),
    .rdata_o   (up_rdata_o)
  );

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> fault_stat_o && irq_en_i);
  // R5
  dn_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_req_o |-> up_req_i);
endmodule

// File: tb/test_secure_xact_filter.sv
`timescale 1ns/1ps
module test_secure_xact_filter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        up_req_i = 1'b0, up_write_i = 1'b0, up_sec_i = 1'b0, up_sec_unspec_i = 1'b0;
  logic [31:0] up_addr_i = '0, up_wdata_i = '0;
  logic [15:0] up_mid_i = '0;
  logic        up_rvalid_o, up_err_o;
  logic [31:0] up_rdata_o;
  logic        dn_req_o, dn_write_o, dn_sec_o;
  logic [31:0] dn_addr_o, dn_wdata_o;
  logic [15:0] dn_mid_o;
  logic [31:0] dn_rdata_i = '0;
  logic [2:0]  lut_idx_o;
  logic [31:0] lut_word_i;
  logic        sec_resp_i = 1'b1, irq_en_i = 1'b1, irq_clr_i = 1'b0;
  logic        irq_o, fault_stat_o;
  logic [31:0] fault_addr_o, fault_info_o;

  logic [31:0] lut [8];
  logic [31:0] mem [256];
  logic [31:0] exp_mem [256];
  logic [32:0] exp_q [$];
  string       tag_q [$];
  logic        exp_stat = 1'b0;
  logic [31:0] exp_info1 = '0, exp_info2 = '0;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign lut_word_i = lut[lut_idx_o];

  secure_xact_filter i_secure_xact_filter (
    .clk_i(clk), .rst_ni(rst_ni),
    .up_req_i(up_req_i), .up_write_i(up_write_i), .up_addr_i(up_addr_i),
    .up_wdata_i(up_wdata_i), .up_sec_i(up_sec_i), .up_sec_unspec_i(up_sec_unspec_i),
    .up_mid_i(up_mid_i), .up_rvalid_o(up_rvalid_o), .up_err_o(up_err_o),
    .up_rdata_o(up_rdata_o), .dn_req_o(dn_req_o), .dn_write_o(dn_write_o),
    .dn_addr_o(dn_addr_o), .dn_wdata_o(dn_wdata_o), .dn_sec_o(dn_sec_o),
    .dn_mid_o(dn_mid_o), .dn_rdata_i(dn_rdata_i), .lut_idx_o(lut_idx_o),
    .lut_word_i(lut_word_i), .sec_resp_i(sec_resp_i), .irq_en_i(irq_en_i),
    .irq_clr_i(irq_clr_i), .irq_o(irq_o), .fault_stat_o(fault_stat_o),
    .fault_addr_o(fault_addr_o), .fault_info_o(fault_info_o)
  );

  // downstream memory, one cycle read latency
  always @(posedge clk) begin
    if (dn_req_o) begin
      if (dn_write_o) mem[dn_addr_o[9:2]] <= dn_wdata_o;
      dn_rdata_i <= mem[dn_addr_o[9:2]];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a response is seen
  always @(posedge clk) begin
    #1;
    if (rst_ni && up_rvalid_o) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected response", 32'd1, 32'd0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " rdata"}, up_rdata_o, e[31:0]);
        check({t, " err"}, {31'd0, up_err_o}, {31'd0, e[32]});
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic w, input logic [31:0] d,
                       input logic s, input logic u, input logic [15:0] m);
    int   blk;
    logic cb, eff, ok;
    blk = int'((a >> 8) & 32'hFF);
    cb  = lut[blk >> 5][blk & 31];
    eff = s | u;
    ok  = (cb != eff);
    up_req_i = 1'b1; up_addr_i = a; up_write_i = w; up_wdata_i = d;
    up_sec_i = s; up_sec_unspec_i = u; up_mid_i = m;
    if (ok) begin
      exp_q.push_back({1'b0, w ? 32'd0 : exp_mem[a[9:2]]});
      tag_q.push_back("R4 permitted");
      if (w) exp_mem[a[9:2]] = d;
    end else begin
      exp_q.push_back({sec_resp_i, 32'd0});
      tag_q.push_back("R6 denied");
      if (!exp_stat) begin
        exp_info1 = a;
        exp_info2 = {14'd0, cb, ~eff, m};
      end
      exp_stat = 1'b1;
    end
    if (ok && irq_clr_i) exp_stat = 1'b0;
    #1;
    check("R1 table index", {29'd0, lut_idx_o}, 32'(blk >> 5));
    check("R2 R5 downstream request", {31'd0, dn_req_o}, {31'd0, ok});
    if (ok) begin
      check("R4 forwarded address", dn_addr_o, a);
      check("R4 forwarded fields", {dn_write_o, dn_sec_o, dn_mid_o, dn_wdata_o[13:0]},
            {w, s, m, d[13:0]});
    end
    @(negedge clk);
  endtask

  task automatic idle();
    up_req_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr_pulse();
    irq_clr_i = 1'b1;
    @(negedge clk);
    irq_clr_i = 1'b0;
    exp_stat  = 1'b0;
    #1;
  endtask

  task automatic check_fault(input string req);
    check({req, " status"}, {31'd0, fault_stat_o}, {31'd0, exp_stat});
    check({req, " irq"}, {31'd0, irq_o}, {31'd0, exp_stat & irq_en_i});
    check({req, " fault addr"}, fault_addr_o, exp_info1);
    check({req, " fault info"}, fault_info_o, exp_info2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    for (int i = 0; i < 8; i++) lut[i] = '0;
    lut[0] = 32'h0000_0002;   // block 1 non-secure
    lut[2] = 32'h8000_0000;   // block 95 non-secure
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check("R11 rvalid", {31'd0, up_rvalid_o}, 32'd0);
    check_fault("R11");
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 secure into secure block, back-to-back
    issue(32'h0010, 1'b1, 32'hAAAA_0001, 1'b1, 1'b0, 16'd5);
    issue(32'h0014, 1'b1, 32'hBBBB_0002, 1'b1, 1'b0, 16'd5);
    issue(32'h0010, 1'b0, 32'h0, 1'b1, 1'b0, 16'd5);
    idle();
    check_fault("R11 no fault yet");

    // R5 R8 non-secure write into secure block
    issue(32'h0014, 1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 16'h1234);
    idle();
    check_fault("R8 first capture");
    check("R8 layout", fault_info_o, 32'h0001_1234);
    issue(32'h0010, 1'b0, 32'h0, 1'b0, 1'b0, 16'h0077);
    idle();
    check_fault("R8 record held");
    issue(32'h0014, 1'b0, 32'h0, 1'b1, 1'b0, 16'd5);   // R5 write was dropped
    idle();

    // R2 non-secure block
    issue(32'h0104, 1'b1, 32'hC0DE_0003, 1'b0, 1'b0, 16'd9);
    issue(32'h0104, 1'b0, 32'h0, 1'b0, 1'b0, 16'd9);
    idle();

    // R7 clear
    clr_pulse();
    check_fault("R7 cleared");

    // R6 OK response for denied access, R2 secure into non-secure block
    sec_resp_i = 1'b0;
    issue(32'h0120, 1'b0, 32'h0, 1'b1, 1'b0, 16'hABCD);
    idle();
    check_fault("R8 cfg bit");
    check("R8 layout cfg", fault_info_o, 32'h0002_ABCD);
    sec_resp_i = 1'b1;

    // R3 unspecified treated as secure
    clr_pulse();
    issue(32'h5F08, 1'b0, 32'h0, 1'b0, 1'b1, 16'h0003);
    idle();
    check_fault("R3 denied in non-secure block");
    check("R3 nonsec flag", fault_info_o, 32'h0002_0003);
    issue(32'h0018, 1'b1, 32'h1111_2222, 1'b0, 1'b1, 16'h0003);
    idle();

    // R9 interrupt gating
    irq_en_i = 1'b0;
    #1;
    check("R9 irq masked", {31'd0, irq_o}, 32'd0);
    irq_en_i = 1'b1;
    #1;
    check("R9 irq enabled", {31'd0, irq_o}, 32'd1);
    @(negedge clk);

    // R7 clear and denial together: status stays set
    irq_clr_i = 1'b1;
    issue(32'h0010, 1'b0, 32'h0, 1'b0, 1'b0, 16'h0001);
    irq_clr_i = 1'b0;
    idle();
    check_fault("R7 set beats clear");
    clr_pulse();
    check_fault("R7 cleared again");

    // R1 address above region wraps to block 1
    issue(32'h0001_0104, 1'b0, 32'h0, 1'b1, 1'b0, 16'h0042);
    idle();
    check_fault("R1 wrap capture");
    check("R1 wrapped record", fault_info_o, 32'h0002_0042);

    repeat (4) @(negedge clk);
    check("R10 all responses seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule